// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous front end of a 32-bit, byte-writable pipelined burst static RAM, together with a behavioural storage array. Every rising clock edge samples the address, the two active-low address strobes, the advance input, three chip enables and the write controls. From these it decides whether the cycle starts a new access, continues or suspends a running burst, or deselects the device.

A burst covers four words. The two low address bits come from a 2-bit beat counter. The counter runs in one of two orders. In linear order it adds the beat to the start offset, modulo 4. In interleaved order it XORs the beat with the start offset. Writes can cover all bytes or a chosen subset of byte lanes. Read data passes through an output register, so it appears one edge after the array access. A combinational output-enable input gates the drive flag, which stands in for a three-state bus.

There are two strobes and they follow different rules. The processor-side strobe only acts when chip enable 1 is active, and then takes priority. The controller-side strobe can start a write in the same cycle, and it deselects the device whenever any chip enable is inactive.

Top module: `pburst_sram_ctrl`

## Requirements
- R1: The processor strobe (`procStrobeN` low) with `ce1N` low starts a read. The read uses `addrIn` when `ce2` is high and `ce3N` is low. This strobe takes priority over the controller strobe, and any write request in that cycle is ignored.
- R2: The processor strobe with `ce1N` high is ignored. A running burst then continues or suspends as `advN` directs, no deselect occurs, and the other chip enables have no effect.
- R3: The controller strobe (`ctrlStrobeN` low, processor strobe not taking effect) deselects when `ce1N` is high, `ce2` is low or `ce3N` is high. After a deselect, no access happens until the next strobe. The output stops driving one cycle after the deselect edge.
- R4: The controller strobe with all enables active starts a write at `addrIn` in that same cycle if a write is requested. Otherwise it starts a read. A cycle never both reads and writes.
- R5: With both strobes high and a burst active, `advN` low moves to the next beat and `advN` high repeats the current address. The cycle is a write if one is requested and a read otherwise.
- R6: With `burstOrder` low (linear), the low two address bits equal (start + beat) mod 4. After the fourth beat the burst wraps back to the start address.
- R7: With `burstOrder` high (interleaved), the low two address bits equal start XOR beat. `burstOrder` is not registered, and a change takes effect on the next address generated.
- R8: `globalWrN` low writes all four bytes. Otherwise, `wrEnN` low writes the bytes whose `byteSelN[i]` is low, where bit i is lane `wrData[8i+7:8i]`. If neither applies, or no select is low, the cycle is a read and memory is not changed.
- R9: Data read at edge k appears on `rdData` with `rdDrive` high after edge k+1, and holds until edge k+2.
- R10: `outEnN` high forces `rdDrive` low and `rdData` to zero at once, without waiting for a clock edge. The output also stops driving after a write cycle and after a deselect.
- R11: A burst begun by the processor strobe takes its write controls and data in the following cycles, at the latched burst address.
- R12: After reset `rdDrive` is low, `rdData` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | External word address |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| globalWrN | input | 1 | Write all bytes, active low |
| wrEnN | input | 1 | Byte-write qualifier, active low |
| byteSelN | input | BYTES | Per-lane byte selects, active low |
| wrData | input | DATA_W | Write data |
| burstOrder | input | 1 | 0 linear, 1 interleaved (unregistered) |
| outEnN | input | 1 | Asynchronous output enable, active low |
| rdData | output | DATA_W | Read data, zero when not driving |
| rdDrive | output | 1 | High when the data outputs would drive |

## Verification
The two strobes can be asserted in the same cycle, and that is the central collision. The bench asserts both together twice. In the first case `ce1N` is high and `ce2` is low, so the controller strobe's deselect must win and the output must go quiet one cycle later. In the second case every enable is active and a global write is requested. The processor strobe must win and produce a read, and a follow-up suspend read of the same word must return the old contents. The expected results come from the bench's own memory image and burst-address arithmetic. A full sweep of both orders across all four start offsets, including the wrap and a suspend, fixes the address sequence around those collisions.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BYTES = 4;

  // Strobes from the control unit to the datapath for one cycle.
  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [BYTES-1:0] byteEn;
  } cmd_t;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic                   procStrobeN,
  input  logic                   ctrlStrobeN,
  input  logic                   advN,
  input  logic                   ce1N,
  input  logic                   ce2,
  input  logic                   ce3N,
  input  logic                   globalWrN,
  input  logic                   wrEnN,
  input  logic [pbs_pkg::BYTES-1:0] byteSelN,
  input  logic                   burstOrder,
  output pbs_pkg::cmd_t          cmd,
  output logic [ADDR_W-1:0]      accAddr
);
  localparam int HI_W = ADDR_W - 2;
  localparam int NB   = pbs_pkg::BYTES;

  typedef enum logic [2:0] {OP_IDLE, OP_START_P, OP_START_C, OP_DESEL, OP_STEP} op_e;

  logic            active;
  logic [HI_W-1:0] baseHi;
  logic [1:0]      startLo;
  logic [1:0]      beat;

  op_e             op;
  logic            enAll, procGo, wrReq;
  logic [NB-1:0]   laneEn;
  logic [1:0]      nextBeat, lowBits;

  always_comb begin
    enAll  = !ce1N && ce2 && !ce3N;
    procGo = !procStrobeN && !ce1N;

    if (!globalWrN)   laneEn = '1;
    else if (!wrEnN)  laneEn = ~byteSelN;
    else              laneEn = '0;
    wrReq = |laneEn;

    if (procGo)            op = enAll ? OP_START_P : OP_DESEL;
    else if (!ctrlStrobeN) op = enAll ? OP_START_C : OP_DESEL;
    else if (active)       op = OP_STEP;
    else                   op = OP_IDLE;

    nextBeat = (op == OP_STEP && !advN) ? 2'(beat + 2'd1) : beat;
    lowBits  = burstOrder ? (startLo ^ nextBeat) : 2'(startLo + nextBeat);

    cmd     = '0;
    accAddr = {baseHi, lowBits};
    unique case (op)
      OP_START_P: begin
        accAddr = addrIn;
        cmd.rd  = 1'b1;
      end
      OP_START_C: begin
        accAddr = addrIn;
        cmd.rd  = !wrReq;
        cmd.wr  = wrReq;
      end
      OP_STEP: begin
        cmd.rd = !wrReq;
        cmd.wr = wrReq;
      end
      default: ;
    endcase
    cmd.byteEn = cmd.wr ? laneEn : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      baseHi  <= '0;
      startLo <= '0;
      beat    <= '0;
    end else begin
      unique case (op)
        OP_START_P, OP_START_C: begin
          active  <= 1'b1;
          baseHi  <= addrIn[ADDR_W-1:2];
          startLo <= addrIn[1:0];
          beat    <= '0;
        end
        OP_DESEL: active <= 1'b0;
        OP_STEP:  beat   <= nextBeat;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbs_pkg::cmd_t     cmd,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = pbs_pkg::BYTES;
  localparam int LANE  = DATA_W / NB;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] outReg;
  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdPend, driveQ;

  // Byte lanes chosen from the new data or the current word.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mergedWord[b*LANE +: LANE] =
      cmd.byteEn[b] ? wrData[b*LANE +: LANE] : mem[accAddr][b*LANE +: LANE];
  end

  always_ff @(posedge clk) begin
    if (cmd.wr) mem[accAddr] <= mergedWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend  <= 1'b0;
      rdAddrQ <= '0;
      outReg  <= '0;
      driveQ  <= 1'b0;
    end else begin
      rdPend  <= cmd.rd;
      rdAddrQ <= accAddr;
      driveQ  <= rdPend;
      if (rdPend) outReg <= mem[rdAddrQ];
    end
  end

  assign rdDrive = driveQ && !outEnN;
  assign rdData  = rdDrive ? outReg : '0;
endmodule

// File: rtl/pburst_sram_ctrl.sv
module pburst_sram_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic                      procStrobeN,
  input  logic                      ctrlStrobeN,
  input  logic                      advN,
  input  logic                      ce1N,
  input  logic                      ce2,
  input  logic                      ce3N,
  input  logic                      globalWrN,
  input  logic                      wrEnN,
  input  logic [pbs_pkg::BYTES-1:0] byteSelN,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      burstOrder,
  input  logic                      outEnN,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdDrive
);
  pbs_pkg::cmd_t     cmdBus;
  logic [ADDR_W-1:0] accAddr;

  pbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .globalWrN(globalWrN), .wrEnN(wrEnN), .byteSelN(byteSelN),
    .burstOrder(burstOrder), .cmd(cmdBus), .accAddr(accAddr)
  );

  pbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmdBus), .accAddr(accAddr),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              outEnN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdDrive,
  input pbs_pkg::cmd_t     cmd,
  input logic [ADDR_W-1:0] accAddr
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R4: one cycle is never both a read and a write
  p_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.rd && cmd.wr));

  // R3: controller strobe with an inactive enable issues no access
  p_desel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && procStrobeN && (ce1N || !ce2 || ce3N)) |-> (!cmd.rd && !cmd.wr));

  // R2: ignored processor strobe lets the running burst advance
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !procStrobeN && ce1N && ctrlStrobeN && !advN &&
     ($past(cmd.rd) || $past(cmd.wr))) |-> ((cmd.rd || cmd.wr) && accAddr != $past(accAddr)));

  // R5: suspend repeats the address
  p_suspend_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && procStrobeN && ctrlStrobeN && advN &&
     ($past(cmd.rd) || $past(cmd.wr))) |-> (accAddr == $past(accAddr)));

  // R9: a read drives the output two edges later
  p_pipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(cmd.rd, 2) && !outEnN) |-> rdDrive);

  // R10: nothing driven when disabled or no read is due
  p_hiz_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN || (sinceRst >= 2'd2 && !$past(cmd.rd, 2))) |-> (!rdDrive && rdData == '0));
endmodule

bind pburst_sram_ctrl pbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .outEnN(outEnN),
  .rdData(rdData), .rdDrive(rdDrive), .cmd(cmdBus), .accAddr(accAddr)
);

// File: tb/tb_pburst_sram_ctrl.sv
`timescale 1ns/1ps
module tb_pburst_sram_ctrl;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic [AW-1:0] addrIn;
  logic procStrobeN, ctrlStrobeN, advN, ce1N, ce2, ce3N;
  logic globalWrN, wrEnN, burstOrder, outEnN;
  logic [3:0] byteSelN;
  logic [DW-1:0] wrData, rdData;
  logic rdDrive;

  always #2 clk = ~clk;

  pburst_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .globalWrN(globalWrN), .wrEnN(wrEnN), .byteSelN(byteSelN), .wrData(wrData),
    .burstOrder(burstOrder), .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

  int tests = 0, fails = 0;
  logic [DW-1:0] model [64];
  bit pendValid = 0;
  logic [DW-1:0] pendData;
  string pendTag = "R12";

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bAddr(input int hi, input int st, input int bt, input bit ord);
    return hi * 4 + (ord ? ((st ^ bt) & 3) : ((st + bt) & 3));
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return (32'(a) * 32'h01020304) ^ 32'hC3A5_0000;
  endfunction

  // One clock; checks the output against the read issued one step earlier.
  task automatic step(input bit expRd, input int ea, input logic [3:0] expWr, input string tag);
    @(posedge clk);
    @(negedge clk);
    if (pendValid)
      chk(rdDrive === 1'b1 && rdData === pendData, pendTag, rdData, pendData);
    else
      chk(rdDrive === 1'b0 && rdData === '0, {pendTag, " quiet"}, {31'd0, rdDrive}, '0);
    for (int b = 0; b < 4; b++)
      if (expWr[b]) model[ea][b*8 +: 8] = wrData[b*8 +: 8];
    pendValid = expRd;
    pendTag   = tag;
    if (expRd) pendData = model[ea];
  endtask

  task automatic setIdle();
    procStrobeN = 1; ctrlStrobeN = 1; advN = 1;
    ce1N = 0; ce2 = 1; ce3N = 0;
    globalWrN = 1; wrEnN = 1; byteSelN = 4'hF;
    addrIn = '0;
  endtask

  task automatic deselect(input string tag);
    setIdle(); ctrlStrobeN = 0; ce2 = 0;
    step(0, 0, 4'h0, tag);
    setIdle(); advN = 0;
    step(0, 0, 4'h0, tag);
    step(0, 0, 4'h0, tag);
  endtask

  task automatic pStart(input int a, input string tag);
    setIdle(); procStrobeN = 0; addrIn = AW'(a);
    step(1, a, 4'h0, tag);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    setIdle(); burstOrder = 0; outEnN = 0; wrData = '0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk(rdDrive === 0 && rdData === '0, "R12 reset", rdData, '0);
    // R12: idle advance without a burst issues nothing
    advN = 0;
    step(0, 0, 4'h0, "R12");
    step(0, 0, 4'h0, "R12");

    // Preload with controller-strobe global writes (R4, R8)
    for (int a = 0; a < 64; a++) begin
      setIdle(); ctrlStrobeN = 0; globalWrN = 0; addrIn = AW'(a); wrData = pat(a);
      step(0, a, 4'hF, "R4");
    end
    deselect("R3");

    // Order/start sweep: R1 start, R6/R7 order, wrap, R5 suspend, R9 latency
    for (int ord = 0; ord < 2; ord++) begin
      for (int st = 0; st < 4; st++) begin
        int hi;
        hi = ord ? 5 : 9;
        burstOrder = ord[0];
        pStart(hi * 4 + st, "R1");
        for (int bt = 1; bt <= 4; bt++) begin
          setIdle(); advN = 0;
          step(1, bAddr(hi, st, bt, ord[0]), 4'h0, ord ? "R7" : "R6");
        end
        setIdle(); advN = 1;
        step(1, bAddr(hi, st, 4, ord[0]), 4'h0, "R5");
        deselect("R3");
      end
    end

    // R2: ignored processor strobe, enables ignored, burst advances
    burstOrder = 0;
    pStart(8, "R1");
    setIdle(); procStrobeN = 0; ce1N = 1; ce2 = 0; advN = 0; addrIn = 6'd40;
    step(1, 9, 4'h0, "R2");
    deselect("R3");

    // R3: deselect by ce1N high and by ce3N high
    pStart(12, "R1");
    setIdle(); ctrlStrobeN = 0; ce1N = 1;
    step(0, 0, 4'h0, "R3");
    setIdle(); advN = 0;
    step(0, 0, 4'h0, "R3");
    step(0, 0, 4'h0, "R3");
    pStart(13, "R1");
    setIdle(); ctrlStrobeN = 0; ce3N = 1;
    step(0, 0, 4'h0, "R3");
    setIdle(); advN = 0;
    step(0, 0, 4'h0, "R3");
    step(0, 0, 4'h0, "R3");

    // R8 / R4: byte writes and read-backs
    setIdle(); ctrlStrobeN = 0; wrEnN = 0; byteSelN = 4'b1010; addrIn = 6'd33; wrData = 32'hDEAD_BEEF;
    step(0, 33, 4'b0101, "R8");
    setIdle(); ctrlStrobeN = 0; addrIn = 6'd33;
    step(1, 33, 4'h0, "R4");
    setIdle(); ctrlStrobeN = 0; wrEnN = 0; byteSelN = 4'hF; addrIn = 6'd33; wrData = 32'h0;
    step(1, 33, 4'h0, "R8");
    setIdle(); ctrlStrobeN = 0; globalWrN = 0; addrIn = 6'd34; wrData = 32'h1234_5678;
    step(0, 34, 4'hF, "R8");
    setIdle(); ctrlStrobeN = 0; addrIn = 6'd34;
    step(1, 34, 4'h0, "R8");
    setIdle(); ctrlStrobeN = 0; globalWrN = 0; wrEnN = 0; byteSelN = 4'b0111; addrIn = 6'd35; wrData = 32'hA1B2_C3D4;
    step(0, 35, 4'hF, "R8");
    setIdle(); ctrlStrobeN = 0; addrIn = 6'd35;
    step(1, 35, 4'h0, "R8");
    deselect("R3");

    // R11: processor-started burst, writes in following cycles
    pStart(50, "R1");
    setIdle(); globalWrN = 0; wrData = 32'h5555_AAAA;
    step(0, 50, 4'hF, "R11");
    setIdle();
    step(1, 50, 4'h0, "R11");
    setIdle(); advN = 0; wrEnN = 0; byteSelN = 4'b1110; wrData = 32'h0000_00EE;
    step(0, 51, 4'b0001, "R11");
    setIdle();
    step(1, 51, 4'h0, "R11");
    deselect("R3");

    // R7: order input unregistered, changed mid-burst
    burstOrder = 0;
    pStart(29, "R1");
    setIdle(); advN = 0;
    step(1, 30, 4'h0, "R6");
    step(1, 31, 4'h0, "R6");
    burstOrder = 1;
    step(1, 30, 4'h0, "R7");
    deselect("R3");
    burstOrder = 0;

    // Both strobes together: deselect wins when ce1N high
    pStart(20, "R1");
    setIdle(); procStrobeN = 0; ctrlStrobeN = 0; ce1N = 1; ce2 = 0;
    step(0, 0, 4'h0, "R3");
    setIdle(); advN = 0;
    step(0, 0, 4'h0, "R3");
    step(0, 0, 4'h0, "R3");
    // processor strobe wins when enabled; write request ignored (R1)
    setIdle(); procStrobeN = 0; ctrlStrobeN = 0; globalWrN = 0; addrIn = 6'd21; wrData = 32'hFFFF_0000;
    step(1, 21, 4'h0, "R1");
    setIdle();
    step(1, 21, 4'h0, "R1");
    deselect("R3");

    // R10: asynchronous output enable
    pStart(40, "R1");
    setIdle(); advN = 0;
    step(1, 41, 4'h0, "R6");
    outEnN = 1; #0.5;
    chk(rdDrive === 0 && rdData === '0, "R10 oe off", rdData, '0);
    outEnN = 0; #0.5;
    chk(rdDrive === 1 && rdData === model[40], "R10 oe on", rdData, model[40]);
    deselect("R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule